// File: doc/BRIEF.md
# Cascaded Serial Bit Sequencer

This block turns a row of neighbouring channels, each holding one data word, into a single serial bit stream. Software-side logic (outside this block) writes the words over a shared data bus with one load strobe per channel. It gives each channel a two-bit mode and sets the enable bits of the channels that should take part. The block checks that the enabled channels form a legal chain and, if so, shifts the stream out on a dedicated output, one bit per asserted tick.

Within a legal chain the channel with the highest index is the tail, and the stream begins there. Each word goes out least significant bit first, and the stream then steps down one channel at a time to the lowest enabled channel. A single channel in solo mode forms a chain of its own. A one-cycle done pulse marks the final bit. With repeat set, the stream wraps back to the tail channel and carries on. The serial output is a path of its own, so channels used here leave their general-purpose pins free.

Top module: `cascade_bit_seq`

## Requirements
- R1: While rst is high, seq_out and seq_done are 0 at every clock edge.
- R2: A high load_en[i] at a clock edge writes load_data into the word of channel i, and the stream afterwards carries that value.
- R3: Within each channel the bits leave in ascending order, bit 0 first and bit WORD_W-1 last.
- R4: A chain is legal when the enabled channels are a contiguous index run of at least two, the highest of them has mode code 2'b10 (tail) and every other one has code 2'b01 (link). The mode of channel i sits in ch_mode[2i+1:2i]. The stream starts at the highest channel and descends to the lowest.
- R5: Leaving idle takes one clock. After that, each cycle with tick_en high puts the next bit on seq_out after that edge. In every cycle with tick_en low, seq_out keeps its value.
- R6: seq_done is high for exactly one cycle, in the same cycle as the last bit of the lowest channel appears. Without repeat, seq_out then holds and ticks have no effect until all enables are cleared.
- R7: With repeat_en high at the final bit, the next tick outputs bit 0 of the highest channel again, and seq_done pulses again at the end of every pass.
- R8: Exactly one enabled channel with mode code 2'b00 (solo) is legal, and the stream is that channel's word alone.
- R9: cfg_error is high whenever some channel is enabled and the configuration is not legal under R4 or R8. Such configurations include a gap, a tail below the top, a lone tail, code 2'b11, and a solo channel inside a run. An illegal configuration never starts the stream.
- R10: Clearing all enables during a stream aborts it. Ticks are ignored while idle, and the next start begins again at bit 0 of the highest channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | NUM_CH | Per-channel word write strobe |
| load_data | input | WORD_W | Word written by the strobed channel |
| ch_mode | input | 2*NUM_CH | Two-bit mode per channel (00 solo, 01 link, 10 tail, 11 reserved) |
| ch_en | input | NUM_CH | Channel enable bits defining the chain |
| repeat_en | input | 1 | Wrap to the tail channel after the final bit |
| tick_en | input | 1 | Advance the stream by one bit |
| seq_out | output | 1 | Serial sequence output |
| seq_done | output | 1 | One-cycle pulse with the final bit |
| cfg_error | output | 1 | Enabled configuration is illegal |

## Verification
The hardest situations to reach from the ports are the boundary crossings: the step from bit WORD_W-1 of one channel to bit 0 of the channel below, and the wrap from the lowest channel back to the tail under repeat. Both happen only after a full word of ticks. The bench loads a distinct computed pattern into every channel, so a wrong channel or a wrong bit index gives a different value. It then walks complete streams for several chain shapes taken from a table and compares every bit, with an idle cycle after each tick to check that the output holds. Illegal shapes come from the same table and are ticked for a long stretch to show that nothing starts. A directed abort in mid-word followed by a restart checks that the read pointers are re-seeded.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [1:0] {
        MODE_SOLO = 2'b00,
        MODE_LINK = 2'b01,
        MODE_TAIL = 2'b10,
        MODE_RSVD = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_HOLD = 2'b10
    } seq_state_e;

    function automatic chan_mode_e mode_of(input logic [1:0] raw);
        return chan_mode_e'(raw);
    endfunction

    // Mode a channel must carry given its place in an enabled run.
    function automatic chan_mode_e needed_mode(input logic is_top, input logic single);
        if (!is_top)
            return MODE_LINK;
        return single ? MODE_SOLO : MODE_TAIL;
    endfunction

endpackage

// File: rtl/cbs_word_bank.sv
module cbs_word_bank #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 32,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] load_en,
    input  logic [WORD_W-1:0] load_data,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic [BIT_W-1:0]  rd_bit,
    output logic              rd_val
);

    logic [WORD_W-1:0] words [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (load_en[g])
                words[g] <= load_data;
        end
    end

    assign rd_val = words[rd_ch][rd_bit];

endmodule

// File: rtl/cbs_chain_check.sv
module cbs_chain_check
    import cbs_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]   ch_en,
    input  logic [2*NUM_CH-1:0] ch_mode,
    output logic                any_en,
    output logic                chain_ok,
    output logic [CH_W-1:0]     lo_idx,
    output logic [CH_W-1:0]     hi_idx
);

    int         en_cnt;
    int         span;
    logic       found;
    logic       modes_ok;
    chan_mode_e m;

    always_comb begin
        lo_idx = '0;
        hi_idx = '0;
        en_cnt = 0;
        found  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_en[i]) begin
                if (!found)
                    lo_idx = CH_W'(i);
                found  = 1'b1;
                hi_idx = CH_W'(i);
                en_cnt = en_cnt + 1;
            end
        end
        span = int'(hi_idx) - int'(lo_idx) + 1;

        modes_ok = 1'b1;
        for (int i = 0; i < NUM_CH; i++) begin
            m = mode_of(ch_mode[2*i +: 2]);
            if (ch_en[i] && (m != needed_mode(CH_W'(i) == hi_idx, en_cnt == 1)))
                modes_ok = 1'b0;
        end

        any_en   = found;
        chain_ok = found && modes_ok && (span == en_cnt);
    end

endmodule

// File: rtl/cbs_engine.sv
module cbs_engine
    import cbs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 32,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any_en,
    input  logic             chain_ok,
    input  logic [CH_W-1:0]  lo_idx,
    input  logic [CH_W-1:0]  hi_idx,
    input  logic             tick_en,
    input  logic             repeat_en,
    input  logic             rd_val,
    output logic [CH_W-1:0]  rd_ch,
    output logic [BIT_W-1:0] rd_bit,
    output logic             seq_out,
    output logic             seq_done,
    output logic             running
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    seq_state_e      state;
    logic [CH_W-1:0] lo_q;
    logic [CH_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            lo_q     <= '0;
            hi_q     <= '0;
            rd_ch    <= '0;
            rd_bit   <= '0;
            seq_out  <= 1'b0;
            seq_done <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (any_en && chain_ok) begin
                        lo_q   <= lo_idx;
                        hi_q   <= hi_idx;
                        rd_ch  <= hi_idx;
                        rd_bit <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!any_en) begin
                        state <= ST_IDLE;
                    end else if (tick_en) begin
                        seq_out <= rd_val;
                        if (rd_bit == LAST_BIT) begin
                            rd_bit <= '0;
                            if (rd_ch == lo_q) begin
                                seq_done <= 1'b1;
                                if (repeat_en)
                                    rd_ch <= hi_q;
                                else
                                    state <= ST_HOLD;
                            end else begin
                                rd_ch <= rd_ch - 1'b1;
                            end
                        end else begin
                            rd_bit <= rd_bit + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!any_en)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign running = (state == ST_RUN);

endmodule

// File: rtl/cascade_bit_seq.sv
module cascade_bit_seq
    import cbs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CH-1:0]   load_en,
    input  logic [WORD_W-1:0]   load_data,
    input  logic [2*NUM_CH-1:0] ch_mode,
    input  logic [NUM_CH-1:0]   ch_en,
    input  logic                repeat_en,
    input  logic                tick_en,
    output logic                seq_out,
    output logic                seq_done,
    output logic                cfg_error
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int BIT_W = $clog2(WORD_W);

    logic             any_en;
    logic             chain_ok;
    logic [CH_W-1:0]  lo_idx;
    logic [CH_W-1:0]  hi_idx;
    logic [CH_W-1:0]  rd_ch;
    logic [BIT_W-1:0] rd_bit;
    logic             rd_val;
    logic             running;

    cbs_word_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_data (load_data),
        .rd_ch     (rd_ch),
        .rd_bit    (rd_bit),
        .rd_val    (rd_val)
    );

    cbs_chain_check #(.NUM_CH(NUM_CH)) u_check (
        .ch_en    (ch_en),
        .ch_mode  (ch_mode),
        .any_en   (any_en),
        .chain_ok (chain_ok),
        .lo_idx   (lo_idx),
        .hi_idx   (hi_idx)
    );

    cbs_engine #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .any_en    (any_en),
        .chain_ok  (chain_ok),
        .lo_idx    (lo_idx),
        .hi_idx    (hi_idx),
        .tick_en   (tick_en),
        .repeat_en (repeat_en),
        .rd_val    (rd_val),
        .rd_ch     (rd_ch),
        .rd_bit    (rd_bit),
        .seq_out   (seq_out),
        .seq_done  (seq_done),
        .running   (running)
    );

    assign cfg_error = any_en && !chain_ok;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic seq_out,
    input logic seq_done,
    input logic cfg_error,
    input logic running
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (seq_out == 1'b0 && !seq_done)); // R1

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(seq_out)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done); // R6

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> $past(tick_en)); // R6

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !running |=> $stable(seq_out)); // R10

    AST_NO_BAD_START: assert property (@(posedge clk) disable iff (rst)
        (!running && cfg_error) |=> !running); // R9

endmodule

bind cascade_bit_seq cbs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .seq_out   (seq_out),
    .seq_done  (seq_done),
    .cfg_error (cfg_error),
    .running   (running)
);

// File: tb/cascade_bit_seq_test.sv
module cascade_bit_seq_test;

    localparam int NUM_CH = 4;
    localparam int WORD_W = 32;

    // Vector fields: [16:13] enables, [12:5] modes, [4] legal, [3:2] low, [1:0] high
    localparam logic [16:0] VEC [8] = '{
        {4'b1111, 8'b10_01_01_01, 1'b1, 2'd0, 2'd3},
        {4'b0110, 8'b00_10_01_00, 1'b1, 2'd1, 2'd2},
        {4'b0100, 8'b00_00_00_00, 1'b1, 2'd2, 2'd2},
        {4'b1011, 8'b10_01_01_01, 1'b0, 2'd0, 2'd0},
        {4'b0011, 8'b00_00_01_10, 1'b0, 2'd0, 2'd0},
        {4'b0010, 8'b00_00_10_00, 1'b0, 2'd0, 2'd0},
        {4'b0001, 8'b00_00_00_11, 1'b0, 2'd0, 2'd0},
        {4'b1100, 8'b10_00_00_00, 1'b0, 2'd0, 2'd0}
    };

    logic                clk = 1'b0;
    logic                rst;
    logic [NUM_CH-1:0]   load_en;
    logic [WORD_W-1:0]   load_data;
    logic [2*NUM_CH-1:0] ch_mode;
    logic [NUM_CH-1:0]   ch_en;
    logic                repeat_en;
    logic                tick_en;
    logic                seq_out;
    logic                seq_done;
    logic                cfg_error;

    logic [WORD_W-1:0] model [NUM_CH];
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cascade_bit_seq #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_data (load_data),
        .ch_mode   (ch_mode),
        .ch_en     (ch_en),
        .repeat_en (repeat_en),
        .tick_en   (tick_en),
        .seq_out   (seq_out),
        .seq_done  (seq_done),
        .cfg_error (cfg_error)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] pattern(int i, int salt);
        return WORD_W'(32'h9E37_79B9 * (i + 3 + salt)) ^ 32'h0F0F_1234;
    endfunction

    task automatic write_word(int ch, logic [WORD_W-1:0] val);
        load_en   = NUM_CH'(1) << ch;
        load_data = val;
        model[ch] = val;
        step();
        load_en = '0;
    endtask

    // Walks one full pass; the engine must already be running.
    task automatic run_stream(int lo, int hi, string tag);
        int total;
        int k;
        logic held;
        total = (hi - lo + 1) * WORD_W;
        k = 0;
        for (int ch = hi; ch >= lo; ch--) begin
            for (int b = 0; b < WORD_W; b++) begin
                tick_en = 1'b1;
                step();
                tick_en = 1'b0;
                check(tag, $sformatf("bit ch%0d[%0d]", ch, b), 32'(seq_out), 32'(model[ch][b]));
                check("R6", "done flag", 32'(seq_done), 32'(k == total - 1));
                held = seq_out;
                step();
                check("R5", "hold between ticks", 32'(seq_out), 32'(held));
                k++;
            end
        end
        held = seq_out;
        tick_en = 1'b1;
        for (int t = 0; t < 3; t++) begin
            step();
            check("R6", "frozen after end", 32'(seq_out), 32'(held));
            check("R6", "no extra done", 32'(seq_done), 32'd0);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic held;
        logic saw_done;
        rst = 1'b1; load_en = '0; load_data = '0; ch_mode = '0;
        ch_en = '0; repeat_en = 1'b0; tick_en = 1'b1;
        step(); step();
        check("R1", "seq_out in reset", 32'(seq_out), 32'd0);
        check("R1", "seq_done in reset", 32'(seq_done), 32'd0);
        rst = 1'b0;
        tick_en = 1'b0;
        step();
        check("R9", "cfg_error with nothing enabled", 32'(cfg_error), 32'd0);

        for (int i = 0; i < NUM_CH; i++)
            write_word(i, pattern(i, 0));

        // Table-driven chain shapes
        for (int v = 0; v < 8; v++) begin
            ch_en   = VEC[v][16:13];
            ch_mode = VEC[v][12:5];
            #1;
            check("R9", $sformatf("cfg_error vector %0d", v), 32'(cfg_error), 32'(!VEC[v][4]));
            if (VEC[v][4]) begin
                step();
                run_stream(int'(VEC[v][3:2]), int'(VEC[v][1:0]),
                           (VEC[v][3:2] == VEC[v][1:0]) ? "R8" : "R4");
            end else begin
                held = seq_out;
                saw_done = 1'b0;
                tick_en = 1'b1;
                for (int t = 0; t < 40; t++) begin
                    step();
                    saw_done = saw_done | seq_done;
                end
                tick_en = 1'b0;
                check("R9", $sformatf("no output, vector %0d", v), 32'(seq_out), 32'(held));
                check("R9", $sformatf("no done, vector %0d", v), 32'(saw_done), 32'd0);
            end
            ch_en = '0;
            step();
        end

        // R3 LSB-first with a sparse word in a solo channel
        write_word(0, 32'h8000_0001);
        ch_en = 4'b0001; ch_mode = 8'b00_00_00_00;
        step();
        run_stream(0, 0, "R3");
        ch_en = '0;
        step();

        // R2 reload then stream
        write_word(1, pattern(1, 7));
        ch_en = 4'b0010; ch_mode = 8'b00_00_00_00;
        step();
        run_stream(1, 1, "R2");
        ch_en = '0;
        step();

        // R7 repeat across two passes
        ch_en = 4'b0110; ch_mode = 8'b00_10_01_00; repeat_en = 1'b1;
        step();
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 2 * WORD_W; k++) begin
                tick_en = 1'b1;
                step();
                check("R7", $sformatf("pass %0d bit %0d", pass, k), 32'(seq_out),
                      32'(model[2 - k / WORD_W][k % WORD_W]));
                check("R7", "done per pass", 32'(seq_done), 32'(k == 2 * WORD_W - 1));
            end
        end
        tick_en = 1'b0; repeat_en = 1'b0; ch_en = '0;
        step();

        // R10 abort mid-word, idle ticks, restart from the top
        ch_en = 4'b1111; ch_mode = 8'b10_01_01_01;
        step();
        tick_en = 1'b1;
        for (int k = 0; k < 10; k++) step();
        check("R10", "bit before abort", 32'(seq_out), 32'(model[3][9]));
        ch_en = '0;
        step();
        step(); step();
        check("R10", "idle ticks ignored", 32'(seq_out), 32'(model[3][9]));
        tick_en = 1'b0;
        ch_en = 4'b1111;
        step();
        tick_en = 1'b1;
        step();
        check("R10", "restart at bit 0 of top", 32'(seq_out), 32'(model[3][0]));
        step();
        check("R10", "restart second bit", 32'(seq_out), 32'(model[3][1]));
        tick_en = 1'b0; ch_en = '0;
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule